// File: doc/BRIEF.md
# AC-link Transmit PCM Channel Buffer

This block is one transmit PCM channel of an AC-link controller. A processor pushes 32-bit words into a small data FIFO. The block takes samples out of the FIFO and hands one sample to the frame formatter for each output slot that the channel owns. The formatter asks for samples one slot at a time. When the channel is enabled and the slot's enable bit is set, the block answers one cycle later with a 20-bit, left-aligned slot value. In compact mode a single FIFO word carries two 16-bit samples, and the low half is sent first. In normal mode each word carries one sample of the programmed width.

Software programs the channel through a small write port. This port reaches the control word, the interrupt enable mask and a write-one-to-clear interrupt register. The block shows a registered status word and a single interrupt line that is masked by the enable register. Disabling the channel leaves queued words in place. Only dropping the interface enable empties the FIFO.

Top module: `ac97_tx_channel`

## Requirements
- R1: After reset, `status` reads 0x00A (only FIFO empty at bit 1 and half-empty at bit 3 set), `irq` is low and `slot_vld` is low.
- R2: In normal mode the control field at bits [14:13] picks the sample width: 00 selects 16 bits, 01 selects 18, 10 selects 20 and 11 selects 12. The sample is taken from the low bits of the word and placed MSB-aligned in the 20-bit `slot_data`, with zero fill below it.
- R3: With the compact bit (control bit 15) set, each word gives two 16-bit samples: bits [15:0] first, then bits [31:16], each placed as `{sample,4'b0}`. The word leaves the FIFO only after its second sample is taken, whatever the width field holds.
- R4: A `slot_req` is answered with `slot_vld` one cycle later only when transmit enable (control bit 0) is set and `slot_num` is 1 to 12 with control bit `slot_num` set. Any other request gives no `slot_vld` and leaves the FIFO unchanged.
- R5: Clearing transmit enable keeps the queued words. They are sent once the channel is enabled again.
- R6: While `if_en` is low the FIFO is emptied and writes to it are dropped.
- R7: With FIFO enable (control bit 16) set, the FIFO holds DEPTH words. Status bit 5 (full) is set at that level, and further writes are dropped.
- R8: With FIFO enable clear, the channel holds a single word. Status bit 5 is set when it is occupied, and a second write is dropped.
- R9: A request for an owned slot while the FIFO is empty returns `slot_data` = 0 with `slot_vld` high. It also sets the sticky underrun bit (status bit 9). Writing 1 to bit 5 at the interrupt clear address clears that bit.
- R10: `irq` is high when interrupt enable bit 5 is set and underrun is pending, or when enable bit 2 is set while transmit is enabled and the FIFO is half empty.
- R11: Status bit 3 (half empty) is set when the level is at most half the active capacity. Status bit 7 (busy) is set when transmit is enabled and the FIFO is not empty. Status bit 1 is set when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_en | input | 1 | Interface enable; low flushes the FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 interrupt enable, 2 interrupt clear |
| reg_wdata | input | 32 | Register write data |
| fifo_wr | input | 1 | FIFO write strobe |
| fifo_wdata | input | 32 | FIFO write word |
| slot_req | input | 1 | Formatter asks for a sample for `slot_num` |
| slot_num | input | 4 | Slot number of the request (1 to 12) |
| slot_vld | output | 1 | Channel supplies `slot_data` for the requested slot |
| slot_data | output | 20 | Left-aligned slot sample |
| status | output | 12 | Registered status word |
| irq | output | 1 | Masked interrupt |

## Verification
The bench covers the following corner cases:
- Compact mode: a design that popped on the first half, or sent the halves in the wrong order, puts words out of order and leaves the empty flag wrong.
- Each width code: a wrong shift shows up as a misplaced sample.
- A FIFO filled one word past capacity, then drained: a design that accepted the extra word would send it in place of the zero underrun sample.
- Requests for unowned slots and requests with the channel disabled, followed by a normal request: a design that consumed on these would lose the queued word.
- Flush through the interface enable, the single-word mode, and the interrupt mask and clear paths.

// File: rtl/ac97tx_pkg.sv
package ac97tx_pkg;
  localparam int CTRL_W      = 17;
  localparam int FEN_BIT     = 16;
  localparam int COMPACT_BIT = 15;
  localparam int SIZE_LO     = 13;
  localparam int TXEN_BIT    = 0;
  localparam int STAT_W      = 12;
  localparam int IE_W        = 7;
  localparam int UR_BIT      = 5;
  localparam int TXREQ_BIT   = 2;
  localparam int SLOT_W      = 20;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_IE   = 2'd1;
  localparam logic [1:0] ADDR_ICLR = 2'd2;

  typedef enum logic [1:0] {
    SZ16 = 2'b00,
    SZ18 = 2'b01,
    SZ20 = 2'b10,
    SZ12 = 2'b11
  } samp_size_e;
endpackage

// File: rtl/txch_fifo.sv
module txch_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [CW-1:0] lim,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          rd_ok, wr_ok;

  assign empty   = (count == '0);
  assign full    = (count >= lim);
  assign rd_ok   = rd_en && !empty;
  assign wr_ok   = wr_en && !flush && (!full || rd_ok);
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  fifo_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
endmodule

// File: rtl/txch_slot_unpack.sv
module txch_slot_unpack
  import ac97tx_pkg::*;
#(
  parameter int NSLOT = 12,
  parameter int SNW   = 4,
  localparam int MEXT = 2 ** SNW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              txen,
  input  logic              compact,
  input  samp_size_e        size,
  input  logic [NSLOT-1:0]  slot_mask,
  input  logic              slot_req,
  input  logic [SNW-1:0]    slot_num,
  input  logic [31:0]       fifo_word,
  input  logic              fifo_empty,
  output logic              pop,
  output logic              slot_vld,
  output logic [SLOT_W-1:0] slot_data,
  output logic              underrun_evt
);
  logic [MEXT-1:0]   mask_ext;
  logic              own, take, upper_half;
  logic [15:0]       half16;
  logic [SLOT_W-1:0] sel;

  assign mask_ext = {{(MEXT - NSLOT - 1){1'b0}}, slot_mask, 1'b0};
  assign own      = txen && slot_req && mask_ext[slot_num];
  assign take     = own && !fifo_empty;
  assign pop      = take && (!compact || upper_half);
  assign half16   = upper_half ? fifo_word[31:16] : fifo_word[15:0];

  always_comb begin
    if (compact) begin
      sel = {half16, 4'b0};
    end else begin
      case (size)
        SZ16:    sel = {fifo_word[15:0], 4'b0};
        SZ18:    sel = {fifo_word[17:0], 2'b0};
        SZ20:    sel = fifo_word[19:0];
        default: sel = {fifo_word[11:0], 8'b0};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush || !compact) upper_half <= 1'b0;
    else if (take)                upper_half <= ~upper_half;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld     <= 1'b0;
      slot_data    <= '0;
      underrun_evt <= 1'b0;
    end else begin
      slot_vld     <= own;
      slot_data    <= take ? sel : '0;
      underrun_evt <= own && fifo_empty;
    end
  end

  // R4
  no_req_no_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_req |=> !slot_vld);

  // R9
  underrun_zero_chk: assert property (@(posedge clk) disable iff (rst)
    underrun_evt |-> (slot_vld && slot_data == '0));
endmodule

// File: rtl/txch_regs.sv
module txch_regs
  import ac97tx_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              underrun_evt,
  input  logic [CW-1:0]     count,
  input  logic [CW-1:0]     lim,
  input  logic              full,
  input  logic              empty,
  output logic [CTRL_W-1:0] ctrl,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [IE_W-1:0]   ie_q;
  logic              ur_q, half_empty, busy, ur_clr;
  logic [STAT_W-1:0] stat_n;

  assign half_empty = (count <= (lim >> 1));
  assign busy       = ctrl[TXEN_BIT] && !empty;
  assign ur_clr     = reg_wr && reg_addr == ADDR_ICLR && reg_wdata[UR_BIT];

  always_comb begin
    stat_n     = '0;
    stat_n[9]  = ur_q;
    stat_n[7]  = busy;
    stat_n[5]  = full;
    stat_n[3]  = half_empty;
    stat_n[1]  = empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      ie_q   <= '0;
      ur_q   <= 1'b0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= reg_wdata[CTRL_W-1:0];
      if (reg_wr && reg_addr == ADDR_IE)   ie_q <= reg_wdata[IE_W-1:0];
      if (underrun_evt)  ur_q <= 1'b1;
      else if (ur_clr)   ur_q <= 1'b0;
      status <= stat_n;
      irq    <= (ie_q[UR_BIT] && ur_q) ||
                (ie_q[TXREQ_BIT] && ctrl[TXEN_BIT] && half_empty);
    end
  end

  // R9
  ur_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ur_q) |-> $past(underrun_evt));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ie_q[UR_BIT]) || $past(ie_q[TXREQ_BIT])));
endmodule

// File: rtl/ac97_tx_channel.sv
module ac97_tx_channel
  import ac97tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NSLOT = 12,
  parameter int SNW   = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              if_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              fifo_wr,
  input  logic [31:0]       fifo_wdata,
  input  logic              slot_req,
  input  logic [SNW-1:0]    slot_num,
  output logic              slot_vld,
  output logic [SLOT_W-1:0] slot_data,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [CW-1:0]     count, lim;
  logic [31:0]       fifo_word;
  logic              full, empty, pop, underrun_evt, flush;

  assign flush = !if_en;
  assign lim   = ctrl[FEN_BIT] ? CW'(DEPTH) : CW'(1);

  txch_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .wr_en   (fifo_wr),
    .wr_data (fifo_wdata),
    .rd_en   (pop),
    .lim     (lim),
    .rd_data (fifo_word),
    .count   (count),
    .full    (full),
    .empty   (empty)
  );

  txch_slot_unpack #(.NSLOT(NSLOT), .SNW(SNW)) u_unpack (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .txen         (ctrl[TXEN_BIT]),
    .compact      (ctrl[COMPACT_BIT]),
    .size         (samp_size_e'(ctrl[SIZE_LO+1:SIZE_LO])),
    .slot_mask    (ctrl[NSLOT:1]),
    .slot_req     (slot_req),
    .slot_num     (slot_num),
    .fifo_word    (fifo_word),
    .fifo_empty   (empty),
    .pop          (pop),
    .slot_vld     (slot_vld),
    .slot_data    (slot_data),
    .underrun_evt (underrun_evt)
  );

  txch_regs #(.CW(CW)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .underrun_evt (underrun_evt),
    .count        (count),
    .lim          (lim),
    .full         (full),
    .empty        (empty),
    .ctrl         (ctrl),
    .status       (status),
    .irq          (irq)
  );
endmodule

// File: tb/ac97_tx_channel_test.sv
`timescale 1ns/1ps
module ac97_tx_channel_test;
  logic        clk = 0, rst = 1, if_en = 1;
  logic        reg_wr = 0, fifo_wr = 0, slot_req = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, fifo_wdata = 0;
  logic [3:0]  slot_num = 0;
  logic        slot_vld, irq;
  logic [19:0] slot_data;
  logic [11:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [19:0] exp_q[$];

  always #5 clk = ~clk;

  ac97_tx_channel uut (
    .clk(clk), .rst(rst), .if_en(if_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .slot_req(slot_req), .slot_num(slot_num),
    .slot_vld(slot_vld), .slot_data(slot_data),
    .status(status), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(bit fen, bit cmp, logic [1:0] sz, logic [11:0] mask, bit txen);
    return {15'b0, fen, cmp, sz, mask, txen};
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); fifo_wr = 1; fifo_wdata = d;
    @(negedge clk); fifo_wr = 0;
  endtask

  // Driver: a request that the channel owns enqueues its expected sample.
  task automatic req(input logic [3:0] n, input bit owned, input logic [19:0] exp);
    if (owned) exp_q.push_back(exp);
    @(negedge clk); slot_req = 1; slot_num = n;
    @(negedge clk); slot_req = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare each produced sample with the queue head (R2 R3 R4 R9).
  always @(negedge clk) begin
    if (!rst && slot_vld) begin
      if (exp_q.size() == 0) chk(0, "R4 unexpected slot_vld", {12'b0, slot_data}, 0);
      else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        chk(slot_data == e, "R2/R3/R9 slot_data", {12'b0, slot_data}, {12'b0, e});
      end
    end
  end

  localparam logic [11:0] M34 = 12'h00C;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    settle();
    // R1
    chk(status == 12'h00A, "R1 status", {20'b0, status}, 32'h00A);
    chk(irq == 0, "R1 irq", {31'b0, irq}, 0);
    chk(slot_vld == 0, "R1 slot_vld", {31'b0, slot_vld}, 0);

    // R2 normal mode, each size
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 1));
    push(32'h0000_1234); push(32'h0000_ABCD);
    req(3, 1, 20'h12340); req(4, 1, 20'hABCD0);
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b01, M34, 1));
    push(32'h0003_FFFF); req(3, 1, 20'hFFFFC);
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b10, M34, 1));
    push(32'hFFFF_F123); req(4, 1, 20'hFF123);
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b11, M34, 1));
    push(32'h0000_0ABC); req(3, 1, 20'hABC00);

    // R3 compact mode, width field ignored
    wr_reg(2'd0, mk_ctrl(1, 1, 2'b10, M34, 1));
    push(32'h5555_AAAA); push(32'h0001_FFFE);
    req(3, 1, 20'hAAAA0); req(4, 1, 20'h55550);
    req(3, 1, 20'hFFFE0);
    settle();
    chk(status[1] == 0, "R3 word held after first half", {20'b0, status}, 0);
    req(4, 1, 20'h00010);
    settle();
    chk(status[1] == 1, "R3 empty after both halves", {20'b0, status}, 32'h2);

    // R4 unowned slots ignored
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 1));
    push(32'h0000_0777);
    req(5, 0, 0); req(0, 0, 0); req(13, 0, 0);
    settle();
    chk(status[1] == 0 && exp_q.size() == 0, "R4 fifo untouched", {20'b0, status}, 0);
    chk(status[7] == 1, "R11 busy", {20'b0, status}, 32'h80);
    req(3, 1, 20'h07770);

    // R5 txen clear keeps contents
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 0));
    push(32'h0000_0111);
    req(3, 0, 0);
    settle();
    chk(status[1] == 0 && status[7] == 0, "R5 kept, not busy", {20'b0, status}, 0);
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 1));
    req(3, 1, 20'h01110);

    // R6 flush, then R9 underrun and R10 interrupt
    push(32'h1); push(32'h2);
    @(negedge clk); if_en = 0;
    @(negedge clk); if_en = 1;
    settle();
    chk(status[1] == 1, "R6 flushed", {20'b0, status}, 32'h2);
    wr_reg(2'd1, 32'h0);
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 0));
    req(3, 0, 0);
    settle();
    chk(status[9] == 0, "R4 no underrun when disabled", {20'b0, status}, 0);
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 1));
    req(3, 1, 20'h0);
    settle();
    chk(status[9] == 1, "R9 underrun set", {20'b0, status}, 32'h200);
    chk(irq == 0, "R10 masked", {31'b0, irq}, 0);
    wr_reg(2'd1, 32'h20);
    settle();
    chk(irq == 1, "R10 underrun irq", {31'b0, irq}, 1);
    wr_reg(2'd2, 32'h20);
    settle();
    chk(status[9] == 0, "R9 cleared", {20'b0, status}, 0);
    chk(irq == 0, "R10 irq dropped", {31'b0, irq}, 0);
    wr_reg(2'd1, 32'h0);

    // R7 full at DEPTH, extra write dropped; R11 half-empty
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 0));
    for (int i = 1; i <= 5; i++) push(32'(i) << 4);
    settle();
    chk(status[3] == 0, "R11 half-empty clear at 5", {20'b0, status}, 0);
    for (int i = 6; i <= 9; i++) push(32'(i) << 4);
    settle();
    chk(status[5] == 1, "R7 full", {20'b0, status}, 32'h20);
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 1));
    for (int i = 1; i <= 8; i++) req(3, 1, 20'(i) << 8);
    req(3, 1, 20'h0);
    settle();
    chk(status[9] == 1, "R7 ninth word dropped", {20'b0, status}, 32'h200);
    wr_reg(2'd2, 32'h20);

    // R8 single-word holding
    wr_reg(2'd0, mk_ctrl(0, 0, 2'b00, M34, 0));
    push(32'h0AAA); push(32'h0BBB);
    settle();
    chk(status[5] == 1, "R8 full at one", {20'b0, status}, 32'h20);
    wr_reg(2'd0, mk_ctrl(0, 0, 2'b00, M34, 1));
    req(3, 1, 20'h0AAA0); req(3, 1, 20'h0);
    wr_reg(2'd2, 32'h20);

    // R10 transmit request interrupt
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 1));
    wr_reg(2'd1, 32'h04);
    settle();
    chk(irq == 1, "R10 half-empty irq", {31'b0, irq}, 1);
    wr_reg(2'd0, mk_ctrl(1, 0, 2'b00, M34, 0));
    settle();
    chk(irq == 0, "R10 no request when disabled", {31'b0, irq}, 0);

    settle();
    chk(exp_q.size() == 0, "R4 all expected samples seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule